// File: doc/BRIEF.md
# SDRAM Open-Row Tracker

This block sits between an access requester and an SDRAM command pins driver. For every accepted request it works out which internal bank the word address falls in, checks whether that bank already has the requested row open, raises a one-cycle hit or miss flag, and plays out the command sequence the access needs: a lone read/write on a hit; precharge, activate and read/write on a miss.

The bank number is two bits wide. Each bit comes from its own selector, which is driven by a 2-bit code. The code either picks one of three address bit positions or forces the bit to zero. One netlist can therefore track four banks, two banks or a single bank. With open-page mode off, every access closes its row again, and nothing is ever recorded as open. An initialisation request precharges every bank and forgets all open rows.

Top module: `rowtrk_top`

## Requirements
- R1: A bank-select code of 0, 1 or 2 makes that bank bit equal to address bit 3, 4 or 5 (default positions). The high selector gives bank bit 1 and the low selector gives bank bit 0. The row is address bits 11:6 and is shown on cmd_row.
- R2: A bank-select code of 3 forces its bank bit to 0, so both codes at 3 map every access to bank 0.
- R3: With open-page mode on, a request whose bank holds the same open row raises hit_flag for one cycle. In that same cycle, the cycle after acceptance, it issues the read or write command, with no precharge or activate.
- R4: With open-page mode on, any other request raises miss_flag for one cycle. It then issues precharge, activate and read/write on three consecutive cycles, starting the cycle after acceptance, and that row becomes the bank's open row.
- R5: Each bank keeps its own open row. Opening a row in one bank leaves the rows recorded for the other banks unchanged.
- R6: With open-page mode off, every request is a miss and issues precharge, activate, read/write and precharge on four consecutive cycles. Its bank is left with no open row, so a later open-page access to that row is a miss.
- R7: An initialisation request seen while idle issues the all-bank precharge the next cycle, and afterwards no bank has an open row.
- R8: req_ready is high only while idle with init_req low. Any command other than NOP keeps it low. A pending init_req takes priority over a simultaneous request, which is not accepted.
- R9: cmd_code encodes NOP=0, precharge=1, all-bank precharge=2, activate=3, read=4, write=5. req_we=1 selects write. cmd_bank and cmd_row carry the request's bank and row for every command except NOP and all-bank precharge.
- R10: After reset, cmd_code is NOP, both flags are low, req_ready is high and no bank has an open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bsel_hi | input | 2 | Selector code for bank bit 1 |
| cfg_bsel_lo | input | 2 | Selector code for bank bit 0 |
| cfg_open_page | input | 1 | Open-page (continuous page) mode enable |
| init_req | input | 1 | Request for the all-bank precharge |
| req_valid | input | 1 | Access request present |
| req_addr | input | AW | Word address of the access |
| req_we | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Request accepted when high with req_valid |
| cmd_code | output | 3 | SDRAM command this cycle |
| cmd_bank | output | 2 | Bank of the command |
| cmd_row | output | AW-6 | Row of the command |
| hit_flag | output | 1 | One-cycle page-hit indication |
| miss_flag | output | 1 | One-cycle page-miss indication |

## Verification
The assertions take the configuration fields and the open-page enable to be steady while a sequence is running. They also take init_req to appear only while the block would otherwise be idle. If these change mid-sequence, the recorded open rows no longer match what the sequencer issued. The bench changes configuration only when req_ready is high, and it raises init_req only between accesses. The one exception is a deliberate collision of init_req with a request, which exercises priority.

// File: rtl/rowtrk_pkg.sv
package rowtrk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_PRE    = 3'd1,
    CMD_PREALL = 3'd2,
    CMD_ACT    = 3'd3,
    CMD_RD     = 3'd4,
    CMD_WR     = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREALL,
    ST_PRE,
    ST_ACT,
    ST_XFER,
    ST_CLOSE
  } st_e;
endpackage

// File: rtl/rowtrk_bank_sel.sv
module rowtrk_bank_sel #(
  parameter int AW = 12,
  parameter int P0 = 3,
  parameter int P1 = 4,
  parameter int P2 = 5
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    code_i,
  output logic          bit_o
);
  always_comb begin
    case (code_i)
      2'd0:    bit_o = addr_i[P0];
      2'd1:    bit_o = addr_i[P1];
      2'd2:    bit_o = addr_i[P2];
      default: bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rowtrk_row_table.sv
module rowtrk_row_table #(
  parameter int NB = 4,
  parameter int BW = 2,
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all_i,
  input  logic          wr_en_i,
  input  logic          wr_keep_i,
  input  logic [BW-1:0] wr_bank_i,
  input  logic [RW-1:0] wr_row_i,
  input  logic [BW-1:0] lk_bank_i,
  input  logic [RW-1:0] lk_row_i,
  output logic          lk_hit_o
);
  logic [NB-1:0] hit_v;
  logic [NB-1:0] vld_v;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          sel;
    logic          vld_q, vld_d;
    logic [RW-1:0] row_q, row_d;

    assign sel = wr_en_i && (wr_bank_i == BW'(b));

    always_comb begin
      vld_d = vld_q;
      row_d = row_q;
      if (clr_all_i) begin
        vld_d = 1'b0;
      end else if (sel) begin
        vld_d = wr_keep_i;
        if (wr_keep_i) row_d = wr_row_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        row_q <= '0;
      end else begin
        vld_q <= vld_d;
        row_q <= row_d;
      end
    end

    assign hit_v[b] = vld_q && (row_q == lk_row_i);
    assign vld_v[b] = vld_q;
  end

  assign lk_hit_o = hit_v[lk_bank_i];

  // R7: an all-bank precharge leaves no bank open
  p_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (vld_v == '0));
endmodule

// File: rtl/rowtrk_cmd_seq.sv
module rowtrk_cmd_seq
  import rowtrk_pkg::*;
#(
  parameter int BW = 2,
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_req_i,
  input  logic          req_valid_i,
  input  logic          req_we_i,
  input  logic          open_page_i,
  input  logic          hit_i,
  input  logic [BW-1:0] bank_i,
  input  logic [RW-1:0] row_i,
  output logic          req_ready_o,
  output logic [2:0]    cmd_o,
  output logic [BW-1:0] bank_o,
  output logic [RW-1:0] row_o,
  output logic          hit_o,
  output logic          miss_o,
  output logic          act_o,
  output logic          keep_o,
  output logic          clr_o
);
  st_e           st_q, st_d;
  logic          accept, take_hit;
  logic [BW-1:0] bank_q;
  logic [RW-1:0] row_q;
  logic          we_q, keep_q, hit_q, miss_q;
  cmd_e          cmd_d;

  assign accept   = (st_q == ST_IDLE) && !init_req_i && req_valid_i;
  assign take_hit = open_page_i && hit_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (init_req_i)       st_d = ST_PREALL;
        else if (req_valid_i) st_d = take_hit ? ST_XFER : ST_PRE;
      end
      ST_PREALL: st_d = ST_IDLE;
      ST_PRE:    st_d = ST_ACT;
      ST_ACT:    st_d = ST_XFER;
      ST_XFER:   st_d = keep_q ? ST_IDLE : ST_CLOSE;
      ST_CLOSE:  st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hit_q  <= accept && take_hit;
      miss_q <= accept && !take_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      we_q   <= 1'b0;
      keep_q <= 1'b0;
    end else if (accept) begin
      bank_q <= bank_i;
      row_q  <= row_i;
      we_q   <= req_we_i;
      keep_q <= open_page_i;
    end
  end

  always_comb begin
    case (st_q)
      ST_PREALL:         cmd_d = CMD_PREALL;
      ST_PRE, ST_CLOSE:  cmd_d = CMD_PRE;
      ST_ACT:            cmd_d = CMD_ACT;
      ST_XFER:           cmd_d = we_q ? CMD_WR : CMD_RD;
      default:           cmd_d = CMD_NOP;
    endcase
  end

  assign cmd_o       = cmd_d;
  assign bank_o      = bank_q;
  assign row_o       = row_q;
  assign hit_o       = hit_q;
  assign miss_o      = miss_q;
  assign act_o       = (st_q == ST_ACT);
  assign keep_o      = keep_q;
  assign clr_o       = (st_q == ST_PREALL);
  assign req_ready_o = (st_q == ST_IDLE) && !init_req_i;

  // R8: busy while any command is on the bus
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != 3'd0) |-> !req_ready_o);
  // R3: a hit shows the transfer command in the flag cycle
  p_hit_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (cmd_o == 3'd4 || cmd_o == 3'd5));
  // R4: a miss starts with precharge, then activate
  p_miss_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |-> (cmd_o == 3'd1));
  p_miss_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |=> (cmd_o == 3'd3));
  // R7: initialisation issues the all-bank precharge next cycle
  p_preall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && init_req_i) |=> (cmd_o == 3'd2));
  // R3/R4: flags are exclusive
  p_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_o && miss_o));
endmodule

// File: rtl/rowtrk_top.sv
module rowtrk_top #(
  parameter int AW      = 12,
  parameter int ROW_LSB = 6,
  parameter int P0      = 3,
  parameter int P1      = 4,
  parameter int P2      = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_bsel_hi,
  input  logic [1:0]            cfg_bsel_lo,
  input  logic                  cfg_open_page,
  input  logic                  init_req,
  input  logic                  req_valid,
  input  logic [AW-1:0]         req_addr,
  input  logic                  req_we,
  output logic                  req_ready,
  output logic [2:0]            cmd_code,
  output logic [1:0]            cmd_bank,
  output logic [AW-ROW_LSB-1:0] cmd_row,
  output logic                  hit_flag,
  output logic                  miss_flag
);
  localparam int RW = AW - ROW_LSB;
  localparam int BW = 2;
  localparam int NB = 1 << BW;

  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic [BW-1:0] bank_sel;
  logic [RW-1:0] row_sel;
  logic          lk_hit, act, keep, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  rowtrk_bank_sel #(.AW(AW), .P0(P0), .P1(P1), .P2(P2)) u_sel_hi (
    .addr_i(req_addr), .code_i(cfg_bsel_hi), .bit_o(bank_sel[1]));
  rowtrk_bank_sel #(.AW(AW), .P0(P0), .P1(P1), .P2(P2)) u_sel_lo (
    .addr_i(req_addr), .code_i(cfg_bsel_lo), .bit_o(bank_sel[0]));

  assign row_sel = req_addr[AW-1:ROW_LSB];

  rowtrk_row_table #(.NB(NB), .BW(BW), .RW(RW)) u_table (
    .clk(clk), .rst_n(rst_n_s),
    .clr_all_i(clr), .wr_en_i(act), .wr_keep_i(keep),
    .wr_bank_i(cmd_bank), .wr_row_i(cmd_row),
    .lk_bank_i(bank_sel), .lk_row_i(row_sel), .lk_hit_o(lk_hit));

  rowtrk_cmd_seq #(.BW(BW), .RW(RW)) u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .init_req_i(init_req), .req_valid_i(req_valid), .req_we_i(req_we),
    .open_page_i(cfg_open_page), .hit_i(lk_hit),
    .bank_i(bank_sel), .row_i(row_sel),
    .req_ready_o(req_ready), .cmd_o(cmd_code),
    .bank_o(cmd_bank), .row_o(cmd_row),
    .hit_o(hit_flag), .miss_o(miss_flag),
    .act_o(act), .keep_o(keep), .clr_o(clr));

  // R2: a forced selector yields a zero bank bit on the command
  p_bank_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_ready && cfg_bsel_hi == 2'b11) |=> !cmd_bank[1]);
  p_bank_lo_zero_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_ready && cfg_bsel_lo == 2'b11) |=> !cmd_bank[0]);
  // R9: the row of an accepted request appears on the command
  p_row_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_ready) |=> (cmd_row == $past(req_addr[AW-1:ROW_LSB])));
endmodule

// File: tb/rowtrk_top_tb.sv
module rowtrk_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_bsel_hi, cfg_bsel_lo;
  logic        cfg_open_page, init_req, req_valid, req_we;
  logic [11:0] req_addr;
  logic        req_ready, hit_flag, miss_flag;
  logic [2:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [5:0]  cmd_row;

  int n_chk = 0;
  int n_bad = 0;
  bit mv [4];
  int mr [4];

  always #2 clk = ~clk;

  rowtrk_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_bsel_hi(cfg_bsel_hi), .cfg_bsel_lo(cfg_bsel_lo),
    .cfg_open_page(cfg_open_page), .init_req(init_req),
    .req_valid(req_valid), .req_addr(req_addr), .req_we(req_we),
    .req_ready(req_ready), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .hit_flag(hit_flag), .miss_flag(miss_flag));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sel_bit(input int code, input logic [11:0] a);
    if (code == 3) return 0;
    return int'(a[3 + code]);
  endfunction

  function automatic int bank_of(input logic [11:0] a);
    return sel_bit(int'(cfg_bsel_hi), a) * 2 + sel_bit(int'(cfg_bsel_lo), a);
  endfunction

  task automatic model_clear();
    for (int b = 0; b < 4; b++) mv[b] = 1'b0;
  endtask

  // entered and left at a negative edge
  task automatic access(input logic [11:0] a, input logic we, input string tag);
    int b, row, exp_n, nbad_seq, nbad_addr;
    bit h;
    int ec [4];
    b   = bank_of(a);
    row = int'(a[11:6]);
    h   = cfg_open_page && mv[b] && (mr[b] == row);
    if (h) begin
      exp_n = 1; ec[0] = we ? 5 : 4;
    end else begin
      exp_n = cfg_open_page ? 3 : 4;
      ec[0] = 1; ec[1] = 3; ec[2] = we ? 5 : 4; ec[3] = 1;
    end
    chk(req_ready == 1'b1, "R8 ready before access", int'(req_ready), 1);
    req_valid = 1'b1; req_addr = a; req_we = we;
    @(negedge clk);
    req_valid = 1'b0;
    chk(hit_flag == h && miss_flag == !h,
        h ? "R3 hit flag" : (cfg_open_page ? "R4 miss flag" : "R6 miss flag"),
        int'(hit_flag), int'(h));
    chk(req_ready == 1'b0, "R8 busy", int'(req_ready), 0);
    nbad_seq = 0; nbad_addr = 0;
    for (int i = 0; i < exp_n; i++) begin
      if (int'(cmd_code) != ec[i]) begin
        nbad_seq++;
        $display("FAIL R9 %s step %0d actual=%0d expected=%0d", tag, i, cmd_code, ec[i]);
      end
      if (int'(cmd_bank) != b || int'(cmd_row) != row) nbad_addr++;
      @(negedge clk);
    end
    n_chk++;
    if (nbad_seq != 0) n_bad++;
    chk(nbad_addr == 0, {tag, " bank/row"}, int'(cmd_bank), b);
    chk(cmd_code == 3'd0 && req_ready, "R8 idle after sequence", int'(cmd_code), 0);
    if (!h) begin
      if (cfg_open_page) begin mv[b] = 1'b1; mr[b] = row; end
      else mv[b] = 1'b0;
    end
  endtask

  task automatic do_init();
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    chk(cmd_code == 3'd2 && !req_ready, "R7 all-bank precharge", int'(cmd_code), 2);
    @(negedge clk);
    chk(cmd_code == 3'd0, "R7 back to idle", int'(cmd_code), 0);
    model_clear();
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hang expected=done");
    finish_run();
  end

  initial begin
    string tag;
    rst_n = 1'b0; cfg_bsel_hi = 2'd3; cfg_bsel_lo = 2'd3; cfg_open_page = 1'b1;
    init_req = 1'b0; req_valid = 1'b0; req_addr = '0; req_we = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cmd_code == 3'd0 && !hit_flag && !miss_flag && req_ready,
        "R10 reset outputs", int'(cmd_code), 0);
    access(12'h145, 1'b0, "R10 first access misses");

    // sweep all selector codes in open-page mode (R1 R2 R3 R4)
    for (int hi = 0; hi < 4; hi++) begin
      for (int lo = 0; lo < 4; lo++) begin
        cfg_bsel_hi = 2'(hi); cfg_bsel_lo = 2'(lo); cfg_open_page = 1'b1;
        tag = (hi == 3 || lo == 3) ? "R2 forced bank bit" : "R1 selected bank bit";
        do_init();
        for (int j = 0; j < 8; j++) begin
          logic [11:0] a;
          a = {(j[0] ? 6'd7 : 6'd5), 3'(j), 3'(j + 1)};
          access(a, 1'b0, tag);
          access(a, 1'b1, tag);
        end
        for (int j = 0; j < 8; j++) access({6'd5, 3'(j), 3'd2}, j[1], tag);
      end
    end

    // R5 banks independent: hi picks bit 4, lo picks bit 3
    cfg_bsel_hi = 2'd1; cfg_bsel_lo = 2'd0;
    do_init();
    access({6'd9,  3'b000, 3'd0}, 1'b0, "R5 open bank0");
    access({6'd12, 3'b001, 3'd0}, 1'b0, "R5 open bank1");
    access({6'd20, 3'b011, 3'd0}, 1'b0, "R5 open bank3");
    access({6'd9,  3'b000, 3'd4}, 1'b0, "R5 bank0 still open");
    chk(hit_flag == 1'b0, "R5 idle flag", int'(hit_flag), 0);
    access({6'd12, 3'b001, 3'd1}, 1'b1, "R5 bank1 still open");

    // R6 open-page mode off
    cfg_open_page = 1'b0;
    for (int j = 0; j < 4; j++) access({6'd9, 3'(j), 3'd0}, j[0], "R6 closed page");
    access({6'd9, 3'b000, 3'd0}, 1'b0, "R6 repeated still misses");
    cfg_open_page = 1'b1;
    access({6'd9, 3'b000, 3'd0}, 1'b0, "R6 nothing left open");

    // R7 init clears open rows
    access({6'd9, 3'b000, 3'd0}, 1'b0, "R7 now open");
    do_init();
    access({6'd9, 3'b000, 3'd0}, 1'b0, "R7 miss after init");

    // R8 init wins over a simultaneous request
    init_req = 1'b1; req_valid = 1'b1; req_addr = 12'h3C0; req_we = 1'b1;
    @(negedge clk);
    init_req = 1'b0; req_valid = 1'b0;
    chk(cmd_code == 3'd2, "R8 init priority", int'(cmd_code), 2);
    @(negedge clk);
    chk(cmd_code == 3'd0 && !hit_flag && !miss_flag, "R8 request dropped",
        int'(cmd_code), 0);
    model_clear();

    finish_run();
  end
endmodule